// File: doc/BRIEF.md
# Chained Hash Region Sequencer

This block feeds an external hash engine from memory. On a start pulse it reads a four-word descriptor for the selected region from a 64-byte aligned list. It then reads the data words that the descriptor points to and hands them to the engine on a valid/ready stream. If the descriptor links to another descriptor, the block reads that one too and goes on feeding the same message. In this way several separate memory areas become one hash input. The final data word carries a last marker.

When the engine returns its eight-word digest, the block writes the words one at a time to the result address that the region's first descriptor names. It then sets two per-region status flags, each only if the first descriptor enabled it. The flags are cleared by writing ones. Separate set and clear vectors control a per-flag interrupt mask. The interrupt output is a level that is high while any flag is both set and unmasked. A read that returns an error ends the walk and sets a sticky error bit.

Top module: `hseq_top`

## Requirements
- R1: After reset: busy, sts, ie, err and irq are 0, and rd_valid, hs_valid and wr_valid are low.
- R2: A start pulse while idle fetches the four descriptor words in order, at byte addresses B + 16*start_region + 4*k for k = 0..3. B is list_base with its six low bits forced to zero. A read request holds rd_valid and rd_addr until rd_ready.
- R3: The descriptor word layout is as follows. Word 0 is the data start byte address. Word 1 is the configuration: bit 31 end-of-message, bit 30 hash-complete flag enable, bit 29 end-of-chain flag enable, bits 15:0 word count minus one. Word 2 is the digest result byte address. Word 3 is the byte address of the next descriptor.
- R4: Each area's words are read at start, start+4, and so on, one read per word. They appear on hs_data in that order. hs_valid, hs_data and hs_last stay stable while hs_ready is low.
- R5: A descriptor whose end-of-message bit is clear and whose next pointer is non-zero is followed by a fetch of the descriptor at that pointer. The walk continues the same message. The walk ends after a descriptor whose end-of-message bit is set or whose next pointer is zero. hs_last is high on that area's final word only. No further descriptor is read.
- R6: After the last word is accepted, the block waits for dg_valid and captures dg_data. It then writes word j (dg_data[32j+31:32j]) to result+4j for j = 0..7 in ascending order. The result address and flag enables come from the first descriptor of the walk only.
- R7: On the edge that accepts the eighth digest write, busy falls. sts[r] (hash complete) is set if that flag was enabled, and sts[NREG+r] (end of chain) is set if that flag was enabled. Here r is the start region.
- R8: A 1 on a bit of sts_clr clears that status bit. A bit that is set and cleared in the same cycle ends set.
- R9: ie_set sets mask bits and ie_clr clears them. If both hit the same bit in the same cycle, the bit ends clear. The ie layout matches sts.
- R10: irq equals the OR over all bits of sts AND ie.
- R11: rsp_err on any descriptor or data read ends the walk. busy falls on that edge, err is set, no digest write occurs and no status bit changes. err stays set until err_clr.
- R12: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a walk |
| start_region | input | RW | Region index whose descriptor begins the walk |
| list_base | input | 32 | Descriptor list base (low six bits ignored) |
| rd_valid | output | 1 | Word read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read byte address |
| rsp_valid | input | 1 | Read response present |
| rsp_data | input | 32 | Read response word |
| rsp_err | input | 1 | Read response error |
| hs_valid | output | 1 | Data word to hash engine valid |
| hs_ready | input | 1 | Hash engine accepts word |
| hs_data | output | 32 | Data word |
| hs_last | output | 1 | Final word of the message |
| dg_valid | input | 1 | Digest present |
| dg_data | input | 32*DG_WORDS | Digest words, word 0 lowest |
| wr_valid | output | 1 | Digest word write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write word |
| sts_clr | input | 2*NREG | Write-one-to-clear for sts |
| ie_set | input | 2*NREG | Mask set |
| ie_clr | input | 2*NREG | Mask clear |
| err_clr | input | 1 | Clear sticky error |
| busy | output | 1 | Walk in progress |
| sts | output | 2*NREG | Hash-complete flags (low half), end-of-chain flags (high half) |
| ie | output | 2*NREG | Interrupt mask |
| err | output | 1 | Sticky read error |
| irq | output | 1 | Masked interrupt level |

## Verification
The bench first runs directed walks. A single one-word area with end-of-message set checks the count-minus-one boundary. A three-area chain that ends on a zero pointer checks linking and where the last marker falls. A chain that ends on end-of-message while its next pointer is non-zero checks that the pointer is not followed; a junk descriptor sits at that pointer and would add extra reads and words. Seeded random walks then vary region, list base low bits, chain length, word counts, termination style, flag enables and ready stalls on every port. Chained descriptors carry inverted flag enables and a decoy result address, which separates first-descriptor settings from later ones. Error responses are injected on a descriptor word and on a data word. Same-cycle set/clear collisions and a start while busy complete the set.

// File: rtl/hseq_pkg.sv
`timescale 1ns/1ps
package hseq_pkg;

    localparam int WORD_W    = 32;
    localparam int ALIGN_LSB = 6;
    localparam int SLOT_LSB  = 4;
    localparam int CNT_W     = 16;
    localparam int EOM_BIT   = 31;
    localparam int HCEN_BIT  = 30;
    localparam int ECEN_BIT  = 29;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DFETCH,
        S_DWAIT,
        S_RFETCH,
        S_RWAIT,
        S_SEND,
        S_DIGEST,
        S_WRITE
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] start;
        logic              eom;
        logic              hc_en;
        logic              ec_en;
        logic [CNT_W-1:0]  cnt_m1;
        logic [WORD_W-1:0] result;
        logic [WORD_W-1:0] next;
    } desc_t;

    function automatic logic [WORD_W-1:0] align_base(logic [WORD_W-1:0] a);
        return a & ~((WORD_W'(1) << ALIGN_LSB) - WORD_W'(1));
    endfunction

    function automatic logic [WORD_W-1:0] slot_addr(logic [WORD_W-1:0] base,
                                                    logic [WORD_W-1:0] idx);
        return align_base(base) + (idx << SLOT_LSB);
    endfunction

    function automatic desc_t desc_load(desc_t d, logic [1:0] idx, logic [WORD_W-1:0] w);
        desc_t r;
        r = d;
        unique case (idx)
            2'd0: r.start = w;
            2'd1: begin
                r.eom    = w[EOM_BIT];
                r.hc_en  = w[HCEN_BIT];
                r.ec_en  = w[ECEN_BIT];
                r.cnt_m1 = w[CNT_W-1:0];
            end
            2'd2: r.result = w;
            default: r.next = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hseq_walker.sv
`timescale 1ns/1ps
module hseq_walker
    import hseq_pkg::*;
#(
    parameter int NREG     = 4,
    parameter int DG_WORDS = 8,
    localparam int RW      = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int WBW     = (DG_WORDS > 1) ? $clog2(DG_WORDS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [RW-1:0]              start_region,
    input  logic [WORD_W-1:0]          list_base,
    output logic                       rd_valid,
    input  logic                       rd_ready,
    output logic [WORD_W-1:0]          rd_addr,
    input  logic                       rsp_valid,
    input  logic [WORD_W-1:0]          rsp_data,
    input  logic                       rsp_err,
    output logic                       hs_valid,
    input  logic                       hs_ready,
    output logic [WORD_W-1:0]          hs_data,
    output logic                       hs_last,
    input  logic                       dg_valid,
    input  logic [WORD_W*DG_WORDS-1:0] dg_data,
    output logic                       wr_valid,
    input  logic                       wr_ready,
    output logic [WORD_W-1:0]          wr_addr,
    output logic [WORD_W-1:0]          wr_data,
    output logic                       busy,
    output logic                       done,
    output logic                       abort,
    output logic [RW-1:0]              done_region,
    output logic                       done_hc,
    output logic                       done_ec
);

    localparam logic [WBW-1:0] WB_LAST = WBW'(DG_WORDS - 1);

    walk_state_e                 state;
    desc_t                       cur;
    logic [WORD_W-1:0]           desc_ptr;
    logic [1:0]                  widx;
    logic                        first_q;
    logic [RW-1:0]               region_q;
    logic                        hc_en_q;
    logic                        ec_en_q;
    logic [WORD_W-1:0]           res_q;
    logic [WORD_W-1:0]           data_addr;
    logic [CNT_W-1:0]            remain;
    logic [WORD_W-1:0]           word_q;
    logic [WORD_W*DG_WORDS-1:0]  dig_q;
    logic [WBW-1:0]              wbi;
    logic                        final_area;
    logic                        rsp_in_wait;

    assign final_area  = cur.eom || (cur.next == '0);
    assign rsp_in_wait = (state == S_DWAIT) || (state == S_RWAIT);

    assign busy     = (state != S_IDLE);
    assign rd_valid = (state == S_DFETCH) || (state == S_RFETCH);
    assign rd_addr  = (state == S_DFETCH) ? desc_ptr + WORD_W'({widx, 2'b00}) : data_addr;
    assign hs_valid = (state == S_SEND);
    assign hs_data  = word_q;
    assign hs_last  = (state == S_SEND) && final_area && (remain == '0);
    assign wr_valid = (state == S_WRITE);
    assign wr_addr  = res_q + WORD_W'({wbi, 2'b00});
    assign wr_data  = dig_q[WORD_W*int'(wbi) +: WORD_W];

    assign done        = (state == S_WRITE) && wr_ready && (wbi == WB_LAST);
    assign abort       = rsp_in_wait && rsp_valid && rsp_err;
    assign done_region = region_q;
    assign done_hc     = hc_en_q;
    assign done_ec     = ec_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur       <= '0;
            desc_ptr  <= '0;
            widx      <= '0;
            first_q   <= 1'b0;
            region_q  <= '0;
            hc_en_q   <= 1'b0;
            ec_en_q   <= 1'b0;
            res_q     <= '0;
            data_addr <= '0;
            remain    <= '0;
            word_q    <= '0;
            dig_q     <= '0;
            wbi       <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        desc_ptr <= slot_addr(list_base, WORD_W'(start_region));
                        widx     <= '0;
                        first_q  <= 1'b1;
                        region_q <= start_region;
                        state    <= S_DFETCH;
                    end
                end
                S_DFETCH: if (rd_ready) state <= S_DWAIT;
                S_DWAIT: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            state <= S_IDLE;
                        end else begin
                            cur <= desc_load(cur, widx, rsp_data);
                            if (widx == 2'd3) begin
                                data_addr <= cur.start;
                                remain    <= cur.cnt_m1;
                                first_q   <= 1'b0;
                                if (first_q) begin
                                    res_q   <= cur.result;
                                    hc_en_q <= cur.hc_en;
                                    ec_en_q <= cur.ec_en;
                                end
                                state <= S_RFETCH;
                            end else begin
                                widx  <= widx + 2'd1;
                                state <= S_DFETCH;
                            end
                        end
                    end
                end
                S_RFETCH: if (rd_ready) state <= S_RWAIT;
                S_RWAIT: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            state <= S_IDLE;
                        end else begin
                            word_q <= rsp_data;
                            state  <= S_SEND;
                        end
                    end
                end
                S_SEND: begin
                    if (hs_ready) begin
                        if (remain == '0) begin
                            if (final_area) begin
                                state <= S_DIGEST;
                            end else begin
                                desc_ptr <= cur.next;
                                widx     <= '0;
                                state    <= S_DFETCH;
                            end
                        end else begin
                            remain    <= remain - CNT_W'(1);
                            data_addr <= data_addr + WORD_W'(4);
                            state     <= S_RFETCH;
                        end
                    end
                end
                S_DIGEST: begin
                    if (dg_valid) begin
                        dig_q <= dg_data;
                        wbi   <= '0;
                        state <= S_WRITE;
                    end
                end
                S_WRITE: begin
                    if (wr_ready) begin
                        if (wbi == WB_LAST) state <= S_IDLE;
                        else                wbi   <= wbi + WBW'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hseq_status.sv
`timescale 1ns/1ps
module hseq_status #(
    parameter int NREG = 4,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int FW  = 2 * NREG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic          abort,
    input  logic [RW-1:0] done_region,
    input  logic          done_hc,
    input  logic          done_ec,
    input  logic [FW-1:0] sts_clr,
    input  logic [FW-1:0] ie_set,
    input  logic [FW-1:0] ie_clr,
    input  logic          err_clr,
    output logic [FW-1:0] sts,
    output logic [FW-1:0] ie,
    output logic          err,
    output logic          irq
);

    logic [FW-1:0] set_vec;

    for (genvar r = 0; r < NREG; r++) begin : g_region
        logic hit;
        assign hit              = done && (done_region == RW'(r));
        assign set_vec[r]       = hit && done_hc;
        assign set_vec[NREG+r]  = hit && done_ec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            ie  <= '0;
            err <= 1'b0;
        end else begin
            sts <= (sts & ~sts_clr) | set_vec;
            ie  <= (ie | ie_set) & ~ie_clr;
            if (abort)        err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    assign irq = |(sts & ie);

endmodule

// File: rtl/hseq_top.sv
`timescale 1ns/1ps
module hseq_top
    import hseq_pkg::*;
#(
    parameter int NREG     = 4,
    parameter int DG_WORDS = 8,
    localparam int RW      = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int FW      = 2 * NREG
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [RW-1:0]              start_region,
    input  logic [WORD_W-1:0]          list_base,
    output logic                       rd_valid,
    input  logic                       rd_ready,
    output logic [WORD_W-1:0]          rd_addr,
    input  logic                       rsp_valid,
    input  logic [WORD_W-1:0]          rsp_data,
    input  logic                       rsp_err,
    output logic                       hs_valid,
    input  logic                       hs_ready,
    output logic [WORD_W-1:0]          hs_data,
    output logic                       hs_last,
    input  logic                       dg_valid,
    input  logic [WORD_W*DG_WORDS-1:0] dg_data,
    output logic                       wr_valid,
    input  logic                       wr_ready,
    output logic [WORD_W-1:0]          wr_addr,
    output logic [WORD_W-1:0]          wr_data,
    input  logic [FW-1:0]              sts_clr,
    input  logic [FW-1:0]              ie_set,
    input  logic [FW-1:0]              ie_clr,
    input  logic                       err_clr,
    output logic                       busy,
    output logic [FW-1:0]              sts,
    output logic [FW-1:0]              ie,
    output logic                       err,
    output logic                       irq
);

    logic          w_done;
    logic          w_abort;
    logic [RW-1:0] w_region;
    logic          w_hc;
    logic          w_ec;

    hseq_walker #(.NREG(NREG), .DG_WORDS(DG_WORDS)) u_walker (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_region (start_region),
        .list_base    (list_base),
        .rd_valid     (rd_valid),
        .rd_ready     (rd_ready),
        .rd_addr      (rd_addr),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_err      (rsp_err),
        .hs_valid     (hs_valid),
        .hs_ready     (hs_ready),
        .hs_data      (hs_data),
        .hs_last      (hs_last),
        .dg_valid     (dg_valid),
        .dg_data      (dg_data),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .busy         (busy),
        .done         (w_done),
        .abort        (w_abort),
        .done_region  (w_region),
        .done_hc      (w_hc),
        .done_ec      (w_ec)
    );

    hseq_status #(.NREG(NREG)) u_status (
        .clk         (clk),
        .rst         (rst),
        .done        (w_done),
        .abort       (w_abort),
        .done_region (w_region),
        .done_hc     (w_hc),
        .done_ec     (w_ec),
        .sts_clr     (sts_clr),
        .ie_set      (ie_set),
        .ie_clr      (ie_clr),
        .err_clr     (err_clr),
        .sts         (sts),
        .ie          (ie),
        .err         (err),
        .irq         (irq)
    );

endmodule

// File: rtl/hseq_chk.sv
`timescale 1ns/1ps
module hseq_chk #(
    parameter int NREG = 4,
    localparam int FW  = 2 * NREG
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [31:0]   rd_addr,
    input logic          hs_valid,
    input logic          hs_ready,
    input logic [31:0]   hs_data,
    input logic          hs_last,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [31:0]   wr_addr,
    input logic [31:0]   wr_data,
    input logic [FW-1:0] sts,
    input logic          err
);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    // R4
    hs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hs_valid && !hs_ready |=> hs_valid && $stable(hs_data) && $stable(hs_last));

    // R5
    last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        hs_last |-> hs_valid);

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R7
    flag_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        (|(sts & ~$past(sts))) |-> $fell(busy));

    // R11
    err_ends_walk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $fell(busy) && !wr_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_valid && !hs_valid && !wr_valid);

endmodule

bind hseq_top hseq_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_addr  (rd_addr),
    .hs_valid (hs_valid),
    .hs_ready (hs_ready),
    .hs_data  (hs_data),
    .hs_last  (hs_last),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sts      (sts),
    .err      (err)
);

// File: tb/tb_hseq_top.sv
`timescale 1ns/1ps
module tb_hseq_top;

    localparam int NREG   = 4;
    localparam int DGW    = 8;
    localparam int FW     = 2 * NREG;
    localparam int RD_LAT = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        start_region = '0;
    logic [31:0]       list_base = '0;
    logic              rd_valid, rd_ready = 1'b0;
    logic [31:0]       rd_addr;
    logic              rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0]       rsp_data = '0;
    logic              hs_valid, hs_ready = 1'b0, hs_last;
    logic [31:0]       hs_data;
    logic              dg_valid = 1'b0;
    logic [32*DGW-1:0] dg_data = '0;
    logic              wr_valid, wr_ready = 1'b0;
    logic [31:0]       wr_addr, wr_data;
    logic [FW-1:0]     sts_clr = '0, ie_set = '0, ie_clr = '0;
    logic              err_clr = 1'b0;
    logic              busy, err, irq;
    logic [FW-1:0]     sts, ie;

    hseq_top #(.NREG(NREG), .DG_WORDS(DGW)) dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] mem [0:4095];
    logic [31:0] exp_q[$], got_q[$], rdq[$], wa_q[$], wd_q[$];
    int          last_cnt, last_idx, exp_reads;
    logic [31:0] exp_desc, exp_res, err_addr = 32'hFFFF_FFFF, dg_base = '0;
    logic [FW-1:0] exp_sts = '0, exp_ie = '0;

    // memory port: one request outstanding, fixed latency
    int          lat_cnt = 0;
    logic [31:0] pend_addr = '0;
    always @(negedge clk) begin
        if (rst) begin
            rsp_valid = 1'b0; rsp_err = 1'b0; lat_cnt = 0; rd_ready = 1'b0;
        end else begin
            rsp_valid = 1'b0; rsp_err = 1'b0;
            if (lat_cnt != 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = mem[pend_addr[13:2]];
                    rsp_err   = (pend_addr == err_addr);
                end
            end
            rd_ready = ($urandom % 4) != 0;
            if (rd_valid && rd_ready) begin
                rdq.push_back(rd_addr);
                pend_addr = rd_addr;
                lat_cnt   = RD_LAT;
            end
        end
    end

    // hash engine and digest return
    int dg_cnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            hs_ready = 1'b0; dg_valid = 1'b0; dg_cnt = 0;
        end else begin
            dg_valid = 1'b0;
            if (dg_cnt != 0) begin
                dg_cnt--;
                if (dg_cnt == 0) dg_valid = 1'b1;
            end
            hs_ready = ($urandom % 3) != 0;
            if (hs_valid && hs_ready) begin
                got_q.push_back(hs_data);
                if (hs_last) begin
                    last_cnt++;
                    last_idx = got_q.size() - 1;
                    dg_cnt   = 3;
                end
            end
        end
    end

    // result write sink
    always @(negedge clk) begin
        if (rst) wr_ready = 1'b0;
        else begin
            wr_ready = ($urandom % 3) != 0;
            if (wr_valid && wr_ready) begin
                wa_q.push_back(wr_addr);
                wd_q.push_back(wr_data);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] aligned(logic [31:0] a);
        return {a[31:6], 6'b0};
    endfunction

    // lay out a chain for region r; term_eom=1 ends on end-of-message with a junk next pointer
    task automatic build(input int r, input int nareas, input bit term_eom,
                         input bit hc, input bit ec, input int fixed_cnt);
        logic [31:0] dptr;
        exp_q.delete();
        exp_desc  = aligned(list_base) + 32'(r * 16);
        exp_res   = 32'h3000 + 32'(r * 64);
        exp_reads = 0;
        dptr      = exp_desc;
        for (int k = 0; k < nareas; k++) begin
            int          cnt;
            logic [31:0] daddr, nxt, cfg;
            bit          lastk;
            cnt   = (fixed_cnt > 0) ? fixed_cnt : 1 + int'($urandom % 8);
            daddr = 32'h2000 + 32'(r * 1024 + k * 64);
            lastk = (k == nareas - 1);
            for (int w = 0; w < cnt; w++) begin
                mem[(daddr >> 2) + 32'(w)] = $urandom;
                exp_q.push_back(mem[(daddr >> 2) + 32'(w)]);
            end
            nxt = lastk ? (term_eom ? 32'h3800 : 32'h0) : 32'h1000 + 32'(r * 256 + (k + 1) * 16);
            cfg = {lastk && term_eom, (k == 0) ? hc : ~hc, (k == 0) ? ec : ~ec,
                   13'd0, 16'(cnt - 1)};
            mem[dptr[13:2]]        = daddr;
            mem[dptr[13:2] + 12'd1] = cfg;
            mem[dptr[13:2] + 12'd2] = (k == 0) ? exp_res : 32'h3C00;
            mem[dptr[13:2] + 12'd3] = nxt;
            exp_reads += 4 + cnt;
            dptr = nxt;
        end
        // junk descriptor that must never be followed
        mem[32'h3800 >> 2]       = 32'h2F00;
        mem[(32'h3800 >> 2) + 1] = 32'h8000_0003;
        mem[(32'h3800 >> 2) + 2] = 32'h3C00;
        mem[(32'h3800 >> 2) + 3] = 32'h0;
    endtask

    task automatic run_walk(input int r, input int extra_region);
        int t;
        got_q.delete(); rdq.delete(); wa_q.delete(); wd_q.delete();
        last_cnt = 0; last_idx = -1;
        dg_base  = $urandom & 32'hFFFF_FF00;
        for (int j = 0; j < DGW; j++) dg_data[32*j +: 32] = dg_base + 32'(j);
        @(negedge clk);
        start = 1'b1; start_region = 2'(r);
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (busy && t < 5000) begin
            if (t == 5 && extra_region >= 0) begin
                start = 1'b1; start_region = 2'(extra_region);
            end else start = 1'b0;
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        if (t >= 5000) chk("R7 walk finishes", 1, 0);
    endtask

    task automatic check_walk(input string tag);
        int bad;
        for (int k = 0; k < 4; k++)
            chk($sformatf("R2 %s desc word %0d addr", tag, k),
                (rdq.size() > k) ? rdq[k] : 32'hDEAD, exp_desc + 32'(4 * k));
        chk($sformatf("R5 %s total reads", tag), rdq.size(), exp_reads);
        bad = 0;
        for (int i = 0; i < exp_q.size(); i++)
            if (i >= got_q.size() || got_q[i] !== exp_q[i]) bad++;
        chk($sformatf("R4 %s stream count", tag), got_q.size(), exp_q.size());
        chk($sformatf("R4 %s stream word mismatches", tag), bad, 0);
        chk($sformatf("R5 %s last marker count", tag), last_cnt, 1);
        chk($sformatf("R5 %s last marker index", tag), last_idx, exp_q.size() - 1);
        bad = 0;
        for (int j = 0; j < wa_q.size(); j++)
            if (wa_q[j] !== exp_res + 32'(4 * j) || wd_q[j] !== dg_base + 32'(j)) bad++;
        chk($sformatf("R6 %s write count", tag), wa_q.size(), DGW);
        chk($sformatf("R6 %s write mismatches", tag), bad, 0);
    endtask

    task automatic walk(input int r, input int n, input bit te, input bit hc, input bit ec,
                        input int fc, input string tag);
        build(r, n, te, hc, ec, fc);
        run_walk(r, -1);
        check_walk(tag);
        if (hc) exp_sts[r] = 1'b1;
        if (ec) exp_sts[NREG + r] = 1'b1;
        chk($sformatf("R7 %s status", tag), sts, exp_sts);
        chk($sformatf("R10 %s irq", tag), irq, |(exp_sts & exp_ie));
    endtask

    task automatic drive_ie(input logic [FW-1:0] s, input logic [FW-1:0] c);
        @(negedge clk);
        ie_set = s; ie_clr = c;
        @(negedge clk);
        ie_set = '0; ie_clr = '0;
        exp_ie = (exp_ie | s) & ~c;
        chk("R9 mask value", ie, exp_ie);
        chk("R10 irq after mask change", irq, |(exp_sts & exp_ie));
    endtask

    task automatic clear_sts(input logic [FW-1:0] m);
        @(negedge clk);
        sts_clr = m;
        @(negedge clk);
        sts_clr = '0;
        exp_sts &= ~m;
        chk("R8 status after clear", sts, exp_sts);
        chk("R10 irq after clear", irq, |(exp_sts & exp_ie));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        list_base = 32'h0000_0800 | 32'h2D;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 sts", sts, 0);
        chk("R1 ie", ie, 0);
        chk("R1 err", err, 0);
        chk("R1 irq", irq, 0);
        chk("R1 request valids", {rd_valid, hs_valid, wr_valid}, 0);

        // R3 single one-word area ending on end-of-message
        walk(0, 1, 1'b1, 1'b1, 1'b1, 1, "R3 single word");
        // R5 three areas ending on zero pointer
        walk(3, 3, 1'b0, 1'b1, 1'b0, 0, "R5 chain zero next");
        // R5 end-of-message stops despite a non-zero pointer
        walk(2, 2, 1'b1, 1'b0, 1'b1, 0, "R5 eom with next");

        // R9 same-cycle set and clear leaves the bit clear
        drive_ie(8'hFF, 8'h00);
        drive_ie(8'h10, 8'h11);
        clear_sts(8'h09);

        // random walks
        for (int i = 0; i < 20; i++) begin
            int r;
            r = int'($urandom % NREG);
            list_base = 32'h0000_0800 | ($urandom & 32'h3F);
            walk(r, 1 + int'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom), 0,
                 $sformatf("R4 random %0d", i));
            drive_ie(8'($urandom), 8'($urandom) & 8'($urandom));
            clear_sts(8'($urandom));
        end

        // R8 set and clear in the same cycle: set wins
        clear_sts(8'hFF);
        build(1, 1, 1'b1, 1'b1, 1'b0, 2);
        sts_clr = 8'h02;
        run_walk(1, -1);
        chk("R8 set beats clear", sts[1], 1'b1);
        sts_clr = '0;
        exp_sts[1] = 1'b1;
        check_walk("R8 collide");

        // R12 start while busy is ignored
        clear_sts(8'hFF);
        build(2, 1, 1'b1, 1'b1, 1'b1, 1);
        build(1, 2, 1'b0, 1'b1, 1'b0, 6);
        run_walk(1, 2);
        check_walk("R12 busy start");
        exp_sts[1] = 1'b1;
        chk("R12 status only first region", sts, exp_sts);
        @(negedge clk);
        @(negedge clk);
        chk("R12 no restart", busy, 0);

        // R11 error on a data read of the second area
        clear_sts(8'hFF);
        build(0, 2, 1'b1, 1'b1, 1'b1, 3);
        err_addr = 32'h2000 + 32'd64 + 32'd4;
        run_walk(0, -1);
        chk("R11 err set on data error", err, 1);
        chk("R11 no digest writes", wa_q.size(), 0);
        chk("R11 status unchanged", sts, exp_sts);
        chk("R11 irq follows err-free status", irq, |(exp_sts & exp_ie));
        @(negedge clk);
        chk("R11 err sticky", err, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R11 err cleared", err, 0);

        // R11 error on a descriptor word
        build(3, 1, 1'b1, 1'b1, 1'b1, 2);
        err_addr = exp_desc + 32'd4;
        run_walk(3, -1);
        chk("R11 err on descriptor", err, 1);
        chk("R11 no data after descriptor error", got_q.size(), 0);
        chk("R11 reads stop at error", rdq.size(), 2);
        chk("R11 status unchanged desc", sts, exp_sts);
        err_addr = 32'hFFFF_FFFF;
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;

        // a clean walk after errors
        walk(3, 2, 1'b0, 1'b0, 1'b1, 0, "R6 after error");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule